// File: doc/BRIEF.md
# Page-Buffered Memory Write Controller

This block sits behind a serial programming front end that has already decoded each command into an operation code, an address and a data byte. It manages writes into two storage arrays. The first is a 16-bit word array that is written one page at a time. The second is an 8-bit byte array that is written either a whole page at a time or one byte at a time. Page writes go through a staging buffer that keeps a valid flag for each entry. The controller commits the buffer into the selected page and models the non-volatile write time with a busy flag that lasts a parameterised number of clock cycles.

For the word array, the front end loads the low byte of a word before its high byte. A high byte that arrives for a word with no low byte loaded is reported for one cycle on `order_err`. That word is then left out of the next commit. A byte-array page commit changes only the bytes that were loaded, and every other byte of the page keeps its value. A single-byte write first erases the target location and then programs the new value. Both arrays can be read combinationally at any time, and an erased location reads as all ones.

The sequencing is done by a state machine with four states. IDLE accepts requests. PROG_WR is the word-array page write. PAGE_WR is the byte-array page write. BYTE_WR is the erase-then-write of a single byte. The transitions are IDLE→PROG_WR on an accepted word-page commit, IDLE→PAGE_WR on an accepted byte-page commit, IDLE→BYTE_WR on an accepted byte write, and each busy state→IDLE once its cycle counter reaches zero.

Top module: `pgbuf_wr_ctrl`

## Requirements
- R1: After reset every word reads 0xFFFF, every byte reads 0xFF, and `busy` and `order_err` are low.
- R2: Operation code 1 stores `req_data` as the low byte and code 2 stores it as the high byte of buffer word `req_addr[PG_WORD_BITS-1:0]`. Code 3 commits the buffer to the page `req_addr[PG_WORD_BITS +: PG_PAGE_BITS]`, and the word at page p, index w reads back at `rd_paddr = {p, w}` as `{high, low}`.
- R3: A word whose low byte was loaded but whose high byte was not is committed with a high byte of 0xFF.
- R4: A code-2 load for a word with no low byte loaded sets `order_err` high in the following cycle only. A code-2 load that follows a low-byte load for the same word leaves `order_err` low. A flagged word is left unchanged by the next commit, even if its low byte is loaded afterwards.
- R5: Code 4 stores a byte at buffer index `req_addr[DP_BYTE_BITS-1:0]`. Code 5 commits to the byte page `req_addr[DP_BYTE_BITS +: DP_PAGE_BITS]` and writes only the loaded indices. All other bytes of that page stay unchanged.
- R6: Code 6 writes `req_data` to byte address `req_addr[DMEM_AW-1:0]`. That location reads 0xFF for as long as `busy` is high, and reads the new value from the cycle in which `busy` falls.
- R7: `busy` rises in the cycle after an accepted commit or byte write. It stays high for exactly PROG_BUSY cycles for a word-page commit and exactly DATA_BUSY cycles for a byte-page commit or a byte write. The array update becomes visible when `busy` falls.
- R8: While `busy` is high, all requests are ignored: loads do not reach the buffers and commits and byte writes do not start.
- R9: After a commit, the valid flags of the committed buffer are clear, so a later commit with no new loads changes nothing.
- R10: Code 0 and code 7 change no state and do not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Operation code (see R2, R5, R6, R10) |
| req_addr | input | ADDR_W | Request address; field use depends on the operation |
| req_data | input | 8 | Request data byte |
| busy | output | 1 | High while a write is in progress |
| order_err | output | 1 | One-cycle pulse on a high-byte load with no low byte loaded |
| rd_paddr | input | PMEM_AW | Word-array read address |
| rd_pword | output | 16 | Word-array read data |
| rd_daddr | input | DMEM_AW | Byte-array read address |
| rd_dbyte | output | 8 | Byte-array read data |

## Verification
On every cycle, the assertions check four things. The length of each busy period matches the write type that started it. Busy only starts from a commit or byte-write request. An ordering error is only reported after a high-byte load made while idle. A single-byte target holds the erased value for the whole write. The bench scenarios are the only way to show the array contents themselves. These cover partial pages, skipped words, the untouched bytes of a data page, requests dropped during busy, and valid flags cleared by a commit. The bench checks them with full sweeps of a small two-page-bit configuration against a reference model.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

    // Operation codes from the decoding front end
    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_LD_PLO   = 3'd1,
        OP_LD_PHI   = 3'd2,
        OP_COMMIT_P = 3'd3,
        OP_LD_D     = 3'd4,
        OP_COMMIT_D = 3'd5,
        OP_WR_BYTE  = 3'd6,
        OP_RSVD     = 3'd7
    } pgbuf_op_e;

    // Write sequencer states
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PROG_WR = 2'd1,
        S_PAGE_WR = 2'd2,
        S_BYTE_WR = 2'd3
    } pgbuf_state_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/pgbuf_wr_fsm.sv
module pgbuf_wr_fsm
    import pgbuf_pkg::*;
#(
    parameter int PROG_BUSY = 40,
    parameter int DATA_BUSY = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_prog,
    input  logic         start_dpage,
    input  logic         start_byte,
    output logic         busy,
    output logic         fin_prog,
    output logic         fin_dpage,
    output logic         fin_byte,
    output pgbuf_state_e state_o
);

    localparam int MAX_BUSY = (PROG_BUSY > DATA_BUSY) ? PROG_BUSY : DATA_BUSY;
    localparam int CNT_W    = $clog2(MAX_BUSY + 1);
    localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_BUSY - 1);
    localparam logic [CNT_W-1:0] DATA_LOAD = CNT_W'(DATA_BUSY - 1);

    pgbuf_state_e     state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Next state and counter
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_prog) begin
                    state_n = S_PROG_WR;
                    cnt_n   = PROG_LOAD;
                end else if (start_dpage) begin
                    state_n = S_PAGE_WR;
                    cnt_n   = DATA_LOAD;
                end else if (start_byte) begin
                    state_n = S_BYTE_WR;
                    cnt_n   = DATA_LOAD;
                end
            end
            S_PROG_WR, S_PAGE_WR, S_BYTE_WR: begin
                if (cnt_zero) begin
                    state_n = S_IDLE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        fin_prog  = 1'b0;
        fin_dpage = 1'b0;
        fin_byte  = 1'b0;
        unique case (state_q)
            S_IDLE:    busy = 1'b0;
            S_PROG_WR: begin
                busy     = 1'b1;
                fin_prog = cnt_zero;
            end
            S_PAGE_WR: begin
                busy      = 1'b1;
                fin_dpage = cnt_zero;
            end
            S_BYTE_WR: begin
                busy     = 1'b1;
                fin_byte = cnt_zero;
            end
            default: busy = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pgbuf_prog_buf.sv
module pgbuf_prog_buf #(
    parameter int WORD_BITS = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_lo,
    input  logic                     ld_hi,
    input  logic [WORD_BITS-1:0]     idx,
    input  logic [7:0]               din,
    input  logic                     clr,
    output logic [(1<<WORD_BITS)-1:0][7:0] lo_q,
    output logic [(1<<WORD_BITS)-1:0][7:0] hi_q,
    output logic [(1<<WORD_BITS)-1:0]      lo_vld,
    output logic [(1<<WORD_BITS)-1:0]      hi_vld,
    output logic [(1<<WORD_BITS)-1:0]      skip,
    output logic                     ord_err
);

    localparam int N_WORDS = 1 << WORD_BITS;

    logic bad_hi;
    assign bad_hi = ld_hi && !lo_vld[idx];

    // One slice per buffered word
    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        logic sel;
        assign sel = (idx == WORD_BITS'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[w]   <= '0;
                hi_q[w]   <= '0;
                lo_vld[w] <= 1'b0;
                hi_vld[w] <= 1'b0;
                skip[w]   <= 1'b0;
            end else if (clr) begin
                lo_vld[w] <= 1'b0;
                hi_vld[w] <= 1'b0;
                skip[w]   <= 1'b0;
            end else if (sel) begin
                if (ld_lo) begin
                    lo_q[w]   <= din;
                    lo_vld[w] <= 1'b1;
                end
                if (ld_hi) begin
                    if (lo_vld[w]) begin
                        hi_q[w]   <= din;
                        hi_vld[w] <= 1'b1;
                    end else begin
                        skip[w] <= 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ord_err <= 1'b0;
        else        ord_err <= bad_hi && !clr;
    end

endmodule

// File: rtl/pgbuf_data_buf.sv
module pgbuf_data_buf #(
    parameter int BYTE_BITS = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ld,
    input  logic [BYTE_BITS-1:0]           idx,
    input  logic [7:0]                     din,
    input  logic                           clr,
    output logic [(1<<BYTE_BITS)-1:0][7:0] byte_q,
    output logic [(1<<BYTE_BITS)-1:0]      vld
);

    localparam int N_BYTES = 1 << BYTE_BITS;

    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q[b] <= '0;
                vld[b]    <= 1'b0;
            end else if (clr) begin
                vld[b] <= 1'b0;
            end else if (ld && (idx == BYTE_BITS'(b))) begin
                byte_q[b] <= din;
                vld[b]    <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pgbuf_wr_ctrl.sv
module pgbuf_wr_ctrl
    import pgbuf_pkg::*;
#(
    parameter int PG_WORD_BITS = 6,
    parameter int PG_PAGE_BITS = 3,
    parameter int DP_BYTE_BITS = 2,
    parameter int DP_PAGE_BITS = 4,
    parameter int PROG_BUSY    = 40,
    parameter int DATA_BUSY    = 20,
    localparam int PMEM_AW     = PG_WORD_BITS + PG_PAGE_BITS,
    localparam int DMEM_AW     = DP_BYTE_BITS + DP_PAGE_BITS,
    localparam int ADDR_W      = (PMEM_AW > DMEM_AW) ? PMEM_AW : DMEM_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [7:0]         req_data,
    output logic               busy,
    output logic               order_err,
    input  logic [PMEM_AW-1:0] rd_paddr,
    output logic [15:0]        rd_pword,
    input  logic [DMEM_AW-1:0] rd_daddr,
    output logic [7:0]         rd_dbyte
);

    localparam int PG_WORDS   = 1 << PG_WORD_BITS;
    localparam int DP_BYTES   = 1 << DP_BYTE_BITS;
    localparam int PMEM_WORDS = 1 << PMEM_AW;
    localparam int DMEM_BYTES = 1 << DMEM_AW;

    // Request decode, gated by busy
    pgbuf_op_e op;
    logic      acc;
    logic      do_ld_lo, do_ld_hi, do_ld_d, do_cp, do_cd, do_wb;

    assign op       = pgbuf_op_e'(req_op);
    assign acc      = req_valid && !busy;
    assign do_ld_lo = acc && (op == OP_LD_PLO);
    assign do_ld_hi = acc && (op == OP_LD_PHI);
    assign do_ld_d  = acc && (op == OP_LD_D);
    assign do_cp    = acc && (op == OP_COMMIT_P);
    assign do_cd    = acc && (op == OP_COMMIT_D);
    assign do_wb    = acc && (op == OP_WR_BYTE);

    // Sequencer
    logic         fin_prog, fin_dpage, fin_byte;
    pgbuf_state_e fsm_state;

    pgbuf_wr_fsm #(
        .PROG_BUSY (PROG_BUSY),
        .DATA_BUSY (DATA_BUSY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (do_cp),
        .start_dpage (do_cd),
        .start_byte  (do_wb),
        .busy        (busy),
        .fin_prog    (fin_prog),
        .fin_dpage   (fin_dpage),
        .fin_byte    (fin_byte),
        .state_o     (fsm_state)
    );

    // Word page buffer
    logic [PG_WORDS-1:0][7:0] pb_lo, pb_hi;
    logic [PG_WORDS-1:0]      pb_lo_v, pb_hi_v, pb_skip;

    pgbuf_prog_buf #(
        .WORD_BITS (PG_WORD_BITS)
    ) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_lo   (do_ld_lo),
        .ld_hi   (do_ld_hi),
        .idx     (req_addr[PG_WORD_BITS-1:0]),
        .din     (req_data),
        .clr     (fin_prog),
        .lo_q    (pb_lo),
        .hi_q    (pb_hi),
        .lo_vld  (pb_lo_v),
        .hi_vld  (pb_hi_v),
        .skip    (pb_skip),
        .ord_err (order_err)
    );

    // Byte page buffer
    logic [DP_BYTES-1:0][7:0] db_byte;
    logic [DP_BYTES-1:0]      db_v;

    pgbuf_data_buf #(
        .BYTE_BITS (DP_BYTE_BITS)
    ) u_dbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (do_ld_d),
        .idx    (req_addr[DP_BYTE_BITS-1:0]),
        .din    (req_data),
        .clr    (fin_dpage),
        .byte_q (db_byte),
        .vld    (db_v)
    );

    // Captured targets and arrays
    logic [PG_PAGE_BITS-1:0] tgt_ppage;
    logic [DP_PAGE_BITS-1:0] tgt_dpage;
    logic [DMEM_AW-1:0]      tgt_baddr;
    logic [7:0]              tgt_bdata;
    logic [15:0]             pmem [PMEM_WORDS];
    logic [7:0]              dmem [DMEM_BYTES];
    logic [7:0]              tgt_byte_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_ppage <= '0;
            tgt_dpage <= '0;
            tgt_baddr <= '0;
            tgt_bdata <= '0;
            for (int i = 0; i < PMEM_WORDS; i++) pmem[i] <= {ERASED_BYTE, ERASED_BYTE};
            for (int i = 0; i < DMEM_BYTES; i++) dmem[i] <= ERASED_BYTE;
        end else begin
            if (do_cp) tgt_ppage <= req_addr[PG_WORD_BITS +: PG_PAGE_BITS];
            if (do_cd) tgt_dpage <= req_addr[DP_BYTE_BITS +: DP_PAGE_BITS];
            if (do_wb) begin
                tgt_baddr <= req_addr[DMEM_AW-1:0];
                tgt_bdata <= req_data;
                dmem[req_addr[DMEM_AW-1:0]] <= ERASED_BYTE;
            end
            if (fin_prog) begin
                for (int w = 0; w < PG_WORDS; w++) begin
                    if (pb_lo_v[w] && !pb_skip[w]) begin
                        pmem[{tgt_ppage, PG_WORD_BITS'(w)}] <=
                            {(pb_hi_v[w] ? pb_hi[w] : ERASED_BYTE), pb_lo[w]};
                    end
                end
            end
            if (fin_dpage) begin
                for (int b = 0; b < DP_BYTES; b++) begin
                    if (db_v[b]) dmem[{tgt_dpage, DP_BYTE_BITS'(b)}] <= db_byte[b];
                end
            end
            if (fin_byte) dmem[tgt_baddr] <= tgt_bdata;
        end
    end

    assign rd_pword     = pmem[rd_paddr];
    assign rd_dbyte     = dmem[rd_daddr];
    assign tgt_byte_now = dmem[tgt_baddr];

endmodule

// File: rtl/pgbuf_wr_chk.sv
module pgbuf_wr_chk
    import pgbuf_pkg::*;
#(
    parameter int PROG_BUSY = 40,
    parameter int DATA_BUSY = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [2:0]   req_op,
    input logic         busy,
    input logic         order_err,
    input pgbuf_state_e fsm_state,
    input logic [7:0]   erased_tgt
);

    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == (($past(fsm_state) == S_PROG_WR) ?
                                  32'(PROG_BUSY) : 32'(DATA_BUSY)));

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && (req_op == OP_COMMIT_P ||
                                             req_op == OP_COMMIT_D ||
                                             req_op == OP_WR_BYTE)));

    // R4
    order_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        order_err |-> $past(req_valid && req_op == OP_LD_PHI && !busy));

    // R6
    erase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == S_BYTE_WR) |-> erased_tgt == 8'hFF);

endmodule

bind pgbuf_wr_ctrl pgbuf_wr_chk #(
    .PROG_BUSY (PROG_BUSY),
    .DATA_BUSY (DATA_BUSY)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .busy       (busy),
    .order_err  (order_err),
    .fsm_state  (fsm_state),
    .erased_tgt (tgt_byte_now)
);

// File: tb/test_pgbuf_wr_ctrl.sv
`timescale 1ns/1ps
module test_pgbuf_wr_ctrl;

    localparam int PGW = 2, PGP = 2, DBB = 2, DPB = 2;
    localparam int TP = 5, TD = 3;
    localparam int PAW = PGW + PGP, DAW = DBB + DPB, AW = 4;
    localparam int NPW = 1 << PAW, NDB = 1 << DAW, NW = 1 << PGW, NB = 1 << DBB;

    logic           clk = 0, rst_n = 0, req_valid = 0;
    logic [2:0]     req_op = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [7:0]     req_data = '0;
    logic           busy, order_err;
    logic [PAW-1:0] rd_paddr = '0;
    logic [15:0]    rd_pword;
    logic [DAW-1:0] rd_daddr = '0;
    logic [7:0]     rd_dbyte;

    int n_tests = 0, n_fail = 0;

    // reference state
    logic [15:0] m_p [NPW];
    logic [7:0]  m_d [NDB];
    logic [7:0]  b_lo [NW], b_hi [NW], b_d [NB];
    logic        b_lov [NW], b_hiv [NW], b_bad [NW], b_dv [NB];

    pgbuf_wr_ctrl #(
        .PG_WORD_BITS (PGW), .PG_PAGE_BITS (PGP),
        .DP_BYTE_BITS (DBB), .DP_PAGE_BITS (DPB),
        .PROG_BUSY (TP), .DATA_BUSY (TD)
    ) i_pgbuf_wr_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .req_data (req_data), .busy (busy),
        .order_err (order_err), .rd_paddr (rd_paddr), .rd_pword (rd_pword),
        .rd_daddr (rd_daddr), .rd_dbyte (rd_dbyte)
    );

    always #4 clk = ~clk;

    task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // Called at a negedge; drives for one cycle, returns at the next negedge
    task automatic req(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_op = 3'd0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sweep(input string rq);
        for (int a = 0; a < NPW; a++) begin
            rd_paddr = PAW'(a); #1;
            check(rq, rd_pword, m_p[a]);
        end
        for (int a = 0; a < NDB; a++) begin
            rd_daddr = DAW'(a); #1;
            check(rq, {8'h00, rd_dbyte}, {8'h00, m_d[a]});
        end
    endtask

    task automatic ld_lo(input int w, input logic [7:0] d);
        req(3'd1, AW'(w), d);
        b_lo[w] = d; b_lov[w] = 1'b1;
    endtask

    task automatic ld_hi(input int w, input logic [7:0] d);
        logic exp_err;
        exp_err = !b_lov[w];
        req(3'd2, AW'(w), d);
        check("R4 order_err", {15'd0, order_err}, {15'd0, exp_err});
        if (exp_err) b_bad[w] = 1'b1;
        else begin b_hi[w] = d; b_hiv[w] = 1'b1; end
    endtask

    task automatic commit_p(input int p);
        int n;
        req(3'd3, AW'(p << PGW), 8'h00);
        wait_idle(n);
        check("R7 prog busy length", 16'(n), 16'(TP));
        for (int w = 0; w < NW; w++) begin
            if (b_lov[w] && !b_bad[w])
                m_p[p*NW + w] = {(b_hiv[w] ? b_hi[w] : 8'hFF), b_lo[w]};
            b_lov[w] = 0; b_hiv[w] = 0; b_bad[w] = 0;
        end
    endtask

    task automatic ld_d(input int b, input logic [7:0] d);
        req(3'd4, AW'(b), d);
        b_d[b] = d; b_dv[b] = 1'b1;
    endtask

    task automatic commit_d(input int p);
        int n;
        req(3'd5, AW'(p << DBB), 8'h00);
        wait_idle(n);
        check("R7 data page busy length", 16'(n), 16'(TD));
        for (int b = 0; b < NB; b++) begin
            if (b_dv[b]) m_d[p*NB + b] = b_d[b];
            b_dv[b] = 0;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < NPW; i++) m_p[i] = 16'hFFFF;
        for (int i = 0; i < NDB; i++) m_d[i] = 8'hFF;
        for (int i = 0; i < NW; i++) begin b_lov[i] = 0; b_hiv[i] = 0; b_bad[i] = 0; end
        for (int i = 0; i < NB; i++) b_dv[i] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {15'd0, busy}, 16'd0);
        check("R1 order_err", {15'd0, order_err}, 16'd0);
        sweep("R1 erased");

        // R2 full word pages, every page
        for (int p = 0; p < (1 << PGP); p++) begin
            for (int w = 0; w < NW; w++) begin
                ld_lo(w, 8'(p*37 + w*11 + 3));
                ld_hi(w, 8'(p*53 + w*7 + 100));
            end
            commit_p(p);
        end
        sweep("R2 page program");

        // R3 / R4 partial and misordered loads on page 1
        ld_lo(0, 8'h3C);
        ld_hi(1, 8'hAA);
        ld_lo(1, 8'h55);
        ld_lo(2, 8'h12);
        ld_hi(2, 8'h34);
        commit_p(1);
        rd_paddr = PAW'(1*NW + 0); #1;
        check("R3 missing high byte", rd_pword, 16'hFF3C);
        rd_paddr = PAW'(1*NW + 1); #1;
        check("R4 skipped word", rd_pword, m_p[1*NW + 1]);
        sweep("R3 R4 page 1");

        // R9 flags cleared: commit of empty buffer leaves page 2 alone
        for (int w = 0; w < NW; w++) begin
            ld_lo(w, 8'(w + 1));
            ld_hi(w, 8'(w + 9));
        end
        commit_p(3);
        commit_p(2);
        sweep("R9 prog flags cleared");

        // R5 data pages, one index left out per page
        for (int p = 0; p < (1 << DPB); p++) begin
            for (int b = 0; b < NB; b++)
                if (b != p) ld_d(b, 8'(p*29 + b*5 + 7));
            commit_d(p);
        end
        sweep("R5 data page partial");

        // R9 data buffer cleared
        commit_d(1);
        sweep("R9 data flags cleared");

        // R6 single byte write at every address
        for (int a = 0; a < NDB; a++) begin
            req(3'd6, AW'(a), 8'(a*19 + 1));
            rd_daddr = DAW'(a); #1;
            check("R6 erased while busy", {8'h00, rd_dbyte}, 16'h00FF);
            wait_idle(n);
            check("R7 byte busy length", 16'(n), 16'(TD));
            m_d[a] = 8'(a*19 + 1);
            check("R6 byte value", {8'h00, rd_dbyte}, {8'h00, m_d[a]});
        end
        sweep("R6 byte writes");

        // R8 requests during busy are dropped
        ld_d(0, 8'hC3);
        req(3'd5, AW'(0), 8'h00);
        check("R8 busy after commit", {15'd0, busy}, 16'd1);
        req(3'd4, AW'(1), 8'h5A);
        req(3'd6, AW'(5), 8'h11);
        wait_idle(n);
        m_d[0] = 8'hC3; b_dv[0] = 0;
        commit_d(1);
        req(3'd3, AW'(0), 8'h00);
        req(3'd2, AW'(0), 8'h77);
        check("R8 no order_err while busy", {15'd0, order_err}, 16'd0);
        wait_idle(n);
        sweep("R8 ignored while busy");

        // R10 reserved and null codes
        req(3'd7, AW'(3), 8'h00);
        check("R10 code 7 no busy", {15'd0, busy}, 16'd0);
        req(3'd0, AW'(3), 8'h00);
        check("R10 code 0 no busy", {15'd0, busy}, 16'd0);
        commit_d(0);
        sweep("R10 no state change");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule